// File: doc/BRIEF.md
# DMA Transmit Channel Enable and Interrupt Controller

This block holds the control and interrupt state of a four-channel DMA transmit engine. Each channel has a run-enable bit. Software changes the enables through two write-only strobes: one that only turns bits on and one that only turns bits off. Because of this, several agents can start or stop their own channels without a read-modify-write race. The current enable vector is driven on `chan_en` to the data movers. The descriptor rings and the data movers are not part of this block.

Each channel reports two kinds of event as one-cycle pulses: a descriptor finished, or a transfer error. Each pulse latches a sticky status bit in that channel's status register. Software clears these bits by writing ones to them. A per-channel mask selects which latched events may raise an interrupt. A summary register gathers the pending unmasked events into one bit per channel, and the single `irq` output is the OR of that vector. All register reads are combinational from the address. Writes take effect at the clock edge where `reg_wen` is sampled high.

Top module: `dmairq_ctrl`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), every register reads zero, `chan_en` is 0 and `irq` is 0.
- R2: A write to offset 0x0000 sets the enable of each channel n whose data bit n is 1 and leaves the other enables unchanged. A read of 0x0000 returns the enable vector in bits [3:0].
- R3: A write to offset 0x0004 clears the enable of each channel n whose data bit n is 1 and leaves the other enables unchanged. A read of 0x0004 returns 0.
- R4: A pulse on `ev_done[n]` sets bit 0 of channel n's status register, and a pulse on `ev_err[n]` sets bit 6. Both take effect at that clock edge and do not depend on the mask. The status register sits at 0x8014 + n*0x400. All its other bits read 0.
- R5: Writing the status register clears each implemented bit written as 1 and keeps each bit written as 0. So writing back a value just read clears exactly the events it showed.
- R6: If an event pulse and a write of 1 to the same status bit arrive in the same cycle, the bit stays set.
- R7: The mask register at 0x8024 + n*0x400 stores bit 0 (descriptor done) and bit 6 (error) from the written data. All its other bits read 0.
- R8: Bit n of the summary register at 0x0034 is 1 exactly when channel n has a status bit that is 1 and whose mask bit is also 1. `irq` is the OR of the summary bits.
- R9: A channel whose mask is 0 never contributes to the summary or to `irq`. Writes to 0x0034 and to unmapped offsets change no state. Channel enables have no effect on status, summary or `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ev_done | input | 4 | Descriptor-done pulse, one bit per channel |
| ev_err | input | 4 | Error pulse, one bit per channel |
| chan_en | output | 4 | Current channel enable vector |
| irq | output | 1 | Combined interrupt request |

## Verification
Directed sequences cover four cases. Set and clear masks with overlapping bits check that each strobe only ever moves bits one way. Status write-backs of the value just read check that only the shown events are cleared. A same-cycle event and clear checks that the event wins. A full-ones mask write checks that only bits 0 and 6 are kept. Random stimulus then mixes event pulses on several channels with writes to every mapped offset, to the summary and to unmapped offsets. Comparing the summary, `irq` and every read-back against a model separates three kinds of fault: a wrong mask selection, a wrong channel address decode, and state that a write which should be ignored has changed.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // Register offsets (bytes)
    localparam int unsigned OFS_EN_SET  = 32'h0000_0000;
    localparam int unsigned OFS_EN_CLR  = 32'h0000_0004;
    localparam int unsigned OFS_SUMMARY = 32'h0000_0034;
    localparam int unsigned OFS_CH_BASE = 32'h0000_8000;
    localparam int unsigned OFS_CH_STEP = 32'h0000_0400;
    localparam int unsigned OFS_STATUS  = 32'h0000_0014;
    localparam int unsigned OFS_MASK    = 32'h0000_0024;

    // Event bit positions inside status and mask
    localparam int unsigned BIT_DONE = 0;
    localparam int unsigned BIT_ERR  = 6;

    typedef struct packed {
        logic err;
        logic done;
    } evflags_t;

    typedef struct packed {
        evflags_t stat;
        evflags_t mask;
    } chan_state_t;

endpackage

// File: rtl/dmairq_enable.sv
module dmairq_enable
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] en
);

    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(OFS_EN_CLR);

    logic [NUM_CH-1:0] en_d, en_q;
    logic [NUM_CH-1:0] bits;

    assign bits = wdata[NUM_CH-1:0];

    wire unused_wdata = ^wdata;

    always_comb begin
        en_d = en_q;
        if (wen && addr == SET_ADDR) begin
            en_d = en_q | bits;
        end else if (wen && addr == CLR_ADDR) begin
            en_d = en_q & ~bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

endmodule

// File: rtl/dmairq_chan_regs.sv
module dmairq_chan_regs
    import dmairq_pkg::*;
#(
    parameter int unsigned CH     = 0,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_done,
    input  logic              ev_err,
    output evflags_t          stat,
    output evflags_t          mask,
    output logic              pend
);

    localparam logic [ADDR_W-1:0] STAT_ADDR =
        ADDR_W'(OFS_CH_BASE + CH * OFS_CH_STEP + OFS_STATUS);
    localparam logic [ADDR_W-1:0] MASK_ADDR =
        ADDR_W'(OFS_CH_BASE + CH * OFS_CH_STEP + OFS_MASK);

    chan_state_t s_d, s_q;
    evflags_t    wbits;

    assign wbits.done = wdata[BIT_DONE];
    assign wbits.err  = wdata[BIT_ERR];

    wire unused_wdata = ^wdata;

    always_comb begin
        s_d = s_q;
        // write-1-to-clear first, then new events override
        if (wen && addr == STAT_ADDR) begin
            s_d.stat.done = s_q.stat.done & ~wbits.done;
            s_d.stat.err  = s_q.stat.err  & ~wbits.err;
        end
        if (ev_done) begin
            s_d.stat.done = 1'b1;
        end
        if (ev_err) begin
            s_d.stat.err = 1'b1;
        end
        if (wen && addr == MASK_ADDR) begin
            s_d.mask = wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat = s_q.stat;
    assign mask = s_q.mask;
    assign pend = (s_q.stat.done & s_q.mask.done) | (s_q.stat.err & s_q.mask.err);

endmodule

// File: rtl/dmairq_readmux.sv
module dmairq_readmux
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] summary,
    input  logic [NUM_CH-1:0] st_done,
    input  logic [NUM_CH-1:0] st_err,
    input  logic [NUM_CH-1:0] mk_done,
    input  logic [NUM_CH-1:0] mk_err,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(OFS_SUMMARY);

    always_comb begin
        rdata = '0;
        if (addr == SET_ADDR) begin
            rdata[NUM_CH-1:0] = en;
        end else if (addr == SUM_ADDR) begin
            rdata[NUM_CH-1:0] = summary;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(OFS_CH_BASE + c * OFS_CH_STEP + OFS_STATUS)) begin
                rdata[BIT_DONE] = st_done[c];
                rdata[BIT_ERR]  = st_err[c];
            end
            if (addr == ADDR_W'(OFS_CH_BASE + c * OFS_CH_STEP + OFS_MASK)) begin
                rdata[BIT_DONE] = mk_done[c];
                rdata[BIT_ERR]  = mk_err[c];
            end
        end
    end

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_err,
    output logic [NUM_CH-1:0] chan_en,
    output logic              irq
);

    logic [NUM_CH-1:0] summary;
    logic [NUM_CH-1:0] st_done_vec, st_err_vec;
    logic [NUM_CH-1:0] mk_done_vec, mk_err_vec;

    dmairq_enable #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (reg_wen),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .en    (chan_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evflags_t stat_c, mask_c;

        dmairq_chan_regs #(
            .CH     (c),
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wen     (reg_wen),
            .addr    (reg_addr),
            .wdata   (reg_wdata),
            .ev_done (ev_done[c]),
            .ev_err  (ev_err[c]),
            .stat    (stat_c),
            .mask    (mask_c),
            .pend    (summary[c])
        );

        assign st_done_vec[c] = stat_c.done;
        assign st_err_vec[c]  = stat_c.err;
        assign mk_done_vec[c] = mask_c.done;
        assign mk_err_vec[c]  = mask_c.err;
    end

    dmairq_readmux #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_readmux (
        .addr    (reg_addr),
        .en      (chan_en),
        .summary (summary),
        .st_done (st_done_vec),
        .st_err  (st_err_vec),
        .mk_done (mk_done_vec),
        .mk_err  (mk_err_vec),
        .rdata   (reg_rdata)
    );

    assign irq = |summary;

endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [NUM_CH-1:0] ev_done,
    input logic [NUM_CH-1:0] ev_err,
    input logic [NUM_CH-1:0] chan_en,
    input logic              irq,
    input logic [NUM_CH-1:0] st_done_vec,
    input logic [NUM_CH-1:0] st_err_vec,
    input logic [NUM_CH-1:0] mk_done_vec,
    input logic [NUM_CH-1:0] mk_err_vec
);

    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(OFS_EN_CLR);

    logic [NUM_CH-1:0] wbits;
    logic              set_wr, clr_wr;

    assign wbits  = reg_wdata[NUM_CH-1:0];
    assign set_wr = reg_wen && reg_addr == SET_ADDR;
    assign clr_wr = reg_wen && reg_addr == CLR_ADDR;

    wire unused_wdata = ^reg_wdata;

    // R2: set strobe turns on every requested channel
    a_r2_set_reaches: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((chan_en & $past(wbits)) == $past(wbits)));

    // R3: clear strobe turns off every requested channel
    a_r3_clear_reaches: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((chan_en & $past(wbits)) == '0));

    // R2 / R3: enables move only on their own strobes
    a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_wr || clr_wr) |=> $stable(chan_en));

    // R6: a done pulse always leaves its status bit set
    a_r6_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_done) |=> ((st_done_vec & $past(ev_done)) == $past(ev_done)));

    // R4: an error pulse always leaves its status bit set
    a_r4_err_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_err) |=> ((st_err_vec & $past(ev_err)) == $past(ev_err)));

    // R9: all-zero masks keep the interrupt low
    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((mk_done_vec | mk_err_vec) == '0) |-> !irq);

    // R8: interrupt only with a pending unmasked event
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|((st_done_vec & mk_done_vec) | (st_err_vec & mk_err_vec))));

endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wen     (reg_wen),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ev_done     (ev_done),
    .ev_err      (ev_err),
    .chan_en     (chan_en),
    .irq         (irq),
    .st_done_vec (st_done_vec),
    .st_err_vec  (st_err_vec),
    .mk_done_vec (mk_done_vec),
    .mk_err_vec  (mk_err_vec)
);

// File: tb/dmairq_ctrl_bench.sv
`timescale 1ns/1ps
module dmairq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ev_done = '0;
    logic [3:0]  ev_err = '0;
    logic [3:0]  chan_en;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    logic [3:0] m_en = '0;
    logic [3:0] m_sd = '0, m_se = '0, m_md = '0, m_me = '0;

    always #2.5 clk = ~clk;

    dmairq_ctrl u_dmairq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_done   (ev_done),
        .ev_err    (ev_err),
        .chan_en   (chan_en),
        .irq       (irq)
    );

    function automatic logic [15:0] stat_addr(input int c);
        return 16'(32'h8014 + c * 32'h400);
    endfunction

    function automatic logic [15:0] mask_addr(input int c);
        return 16'(32'h8024 + c * 32'h400);
    endfunction

    function automatic logic [3:0] exp_sum();
        return (m_sd & m_md) | (m_se & m_me);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [15:0] a);
        logic [31:0] v = '0;
        if (a == 16'h0000) v[3:0] = m_en;
        if (a == 16'h0034) v[3:0] = exp_sum();
        for (int c = 0; c < 4; c++) begin
            if (a == stat_addr(c)) begin v[0] = m_sd[c]; v[6] = m_se[c]; end
            if (a == mask_addr(c)) begin v[0] = m_md[c]; v[6] = m_me[c]; end
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive after negedge, model updates with the edge
    task automatic tick(input logic we, input logic [15:0] a, input logic [31:0] d,
                        input logic [3:0] dn, input logic [3:0] er);
        reg_wen = we; reg_addr = a; reg_wdata = d; ev_done = dn; ev_err = er;
        @(posedge clk);
        if (we) begin
            if (a == 16'h0000) m_en = m_en | d[3:0];
            if (a == 16'h0004) m_en = m_en & ~d[3:0];
            for (int c = 0; c < 4; c++) begin
                if (a == stat_addr(c)) begin
                    if (d[0]) m_sd[c] = 1'b0;
                    if (d[6]) m_se[c] = 1'b0;
                end
                if (a == mask_addr(c)) begin
                    m_md[c] = d[0]; m_me[c] = d[6];
                end
            end
        end
        m_sd = m_sd | dn;
        m_se = m_se | er;
        @(negedge clk);
        reg_wen = 1'b0; ev_done = '0; ev_err = '0;
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp_rd(a));
    endtask

    task automatic outs(input string tag);
        check({tag, " chan_en"}, {28'd0, chan_en}, {28'd0, m_en});
        check({tag, " irq"}, {31'd0, irq}, {31'd0, |exp_sum()});
    endtask

    task automatic rd_all(input string tag);
        rd({tag, " en"}, 16'h0000);
        rd({tag, " clr"}, 16'h0004);
        rd({tag, " sum"}, 16'h0034);
        for (int c = 0; c < 4; c++) begin
            rd({tag, " stat"}, stat_addr(c));
            rd({tag, " mask"}, mask_addr(c));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        outs("R1 reset");
        rd_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: set strobe
        tick(1'b1, 16'h0000, 32'h5, '0, '0);
        outs("R2 set 0101");
        tick(1'b1, 16'h0000, 32'h2, '0, '0);
        outs("R2 set 0010 keeps others");
        rd("R2 readback", 16'h0000);

        // R3: clear strobe
        tick(1'b1, 16'h0004, 32'h4, '0, '0);
        outs("R3 clear 0100");
        rd("R3 clr reads zero", 16'h0004);
        rd("R3 enable readback", 16'h0000);

        // R4 / R9: events latch without mask, irq stays low
        tick(1'b0, '0, '0, 4'b0100, 4'b0010);
        rd("R4 ch2 done", stat_addr(2));
        rd("R4 ch1 err", stat_addr(1));
        outs("R9 masked off");
        rd("R9 sum masked", 16'h0034);

        // R7: mask keeps bits 0 and 6 only
        tick(1'b1, mask_addr(1), 32'hFFFF_FFFF, '0, '0);
        rd("R7 mask ones", mask_addr(1));
        check("R7 mask value", reg_rdata, 32'h41);
        // R8: ch1 error now unmasked
        outs("R8 irq on");
        rd("R8 summary", 16'h0034);

        // R9: enable has no effect on irq; summary write ignored
        tick(1'b1, 16'h0004, 32'hF, '0, '0);
        outs("R9 enables off");
        tick(1'b1, 16'h0034, 32'hFFFF_FFFF, '0, '0);
        rd_all("R9 summary write ignored");
        tick(1'b1, 16'h1234, 32'hFFFF_FFFF, '0, '0);
        rd_all("R9 unmapped write ignored");

        // R5: write back read value
        reg_addr = stat_addr(1); #0.5; v = reg_rdata;
        tick(1'b1, stat_addr(1), v, '0, '0);
        rd("R5 writeback cleared", stat_addr(1));
        check("R5 stat zero", reg_rdata, 32'h0);
        outs("R5 irq off");
        tick(1'b1, stat_addr(2), 32'h40, '0, '0);
        rd("R5 zero bit kept", stat_addr(2));
        check("R5 done kept", reg_rdata, 32'h1);

        // R6: event vs clear collision
        tick(1'b1, mask_addr(2), 32'h1, '0, '0);
        tick(1'b1, stat_addr(2), 32'h41, 4'b0100, '0);
        rd("R6 event wins", stat_addr(2));
        check("R6 bit set", reg_rdata, 32'h1);
        outs("R6 irq");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [31:0] d;
            int c;
            c = int'($urandom_range(0, 3));
            case ($urandom_range(0, 7))
                0: a = 16'h0000;
                1: a = 16'h0004;
                2, 3: a = stat_addr(c);
                4: a = mask_addr(c);
                5: a = 16'h0034;
                6: a = 16'($urandom);
                default: a = 16'h0000;
            endcase
            d = $urandom;
            tick(1'($urandom_range(0, 1)), a, d,
                 4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom) & 4'($urandom));
            outs("R8 random");
            if (i % 8 == 0) rd_all("R4 R5 R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule